// File: doc/BRIEF.md
# Parallel-Lane Waveform Sequencer

This block feeds a fast DAC path with sixteen samples per fabric clock. The downstream serializer (not part of this block) turns each sixteen-sample word into a stream at sixteen times the fabric rate. There are two ways to fill the word. The first is direct digital synthesis. Here a 32-bit phase accumulator indexes a 2048-entry table that holds exactly one period of a waveform. An optional stepped frequency sweep can run on top of it. The second is arbitrary playback. Here the same table is read as a buffer of sixteen-sample words, played in order and looped.

Before a run, the host loads the table through a write port while the block is idle. A read port returns any entry one clock after its address is presented. A run is armed first, and it starts on a rising edge of the trigger input. The trigger output marks the last word of every waveform period or buffer pass. A stop request returns the outputs to mid-scale, which is the code zero.

The sample stream has a valid flag but no ready. The DAC takes a word every cycle, so there is no back-pressure. A consumer must accept every word for which `smp_valid` is high.

Top module: `lane_wavegen`

## Requirements
- R1: After reset, and whenever no run is in progress, `smp_valid` and `trig_out` are 0 and all of `smp_lanes` is 0.
- R2: While idle, a write with `host_wr_en` high stores `host_wr_data` at `host_wr_addr`. `host_rd_data` shows the entry at `host_rd_addr` one clock after that address is presented.
- R3: A table write attempted while armed or running is discarded, and the entry keeps its old value.
- R4: A pulse on `arm` moves the idle block to the armed state. A run starts only on a rising edge of `trig_in` seen while armed. A level that is already high when arming does not count as an edge.
- R5: The first word of a run appears, with `smp_valid` high, on the second rising clock edge after the edge where `trig_in` is first sampled high while armed.
- R6: With `mode_arb` = 0 and the sweep off, word n of a run has, in lane k (bits `k*14 +: 14` of `smp_lanes`), the table entry addressed by bits 31..21 of (16·n·T + k·T) mod 2^32, where T is `tune_word`.
- R7: In DDS mode, `trig_out` is high together with word n exactly when the word's base phase plus 16·T carries out of 32 bits.
- R8: With `mode_arb` = 1, lane k of the w-th word holds table entry 16·w + k. Here w counts 0 up to `arb_last_word` and then restarts at 0, so a pass is (`arb_last_word`+1)·16 samples.
- R9: In arbitrary mode, `trig_out` is high together with the word whose index equals `arb_last_word`.
- R10: With `sweep_en` = 1, each tuning value is used for `sweep_hold`+1 words. The next value is the current one plus `sweep_step`. If that sum would exceed `sweep_max`, the next value is `tune_word` again. Every run begins at `tune_word`.
- R11: A `stop` pulse ends a run or cancels an armed state. Two clock edges later, `smp_valid` and `smp_lanes` are 0. A trigger edge after a cancelled arm starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Table write strobe (honoured only while idle) |
| host_wr_addr | input | 11 | Table write address |
| host_wr_data | input | 14 | Table write sample, two's complement |
| host_rd_addr | input | 11 | Table readback address |
| host_rd_data | output | 14 | Table entry, one clock after address |
| mode_arb | input | 1 | 0 selects DDS, 1 selects arbitrary playback; sampled at run start |
| tune_word | input | 32 | Phase increment per sample, and the sweep start value |
| sweep_en | input | 1 | Enables the stepped sweep in DDS mode |
| sweep_step | input | 32 | Tuning increment added per sweep step |
| sweep_max | input | 32 | Largest tuning value the sweep may reach |
| sweep_hold | input | 16 | Words per sweep step, minus one |
| arb_last_word | input | 7 | Index of the final word of the playback buffer |
| arm | input | 1 | Arms the block for a trigger |
| stop | input | 1 | Ends a run or cancels arming; has priority over arm |
| trig_in | input | 1 | Start trigger, rising-edge sensitive |
| trig_out | output | 1 | One-word marker on the last word of each period or pass |
| smp_valid | output | 1 | High while `smp_lanes` carries a run's samples |
| smp_lanes | output | 224 | Sixteen 14-bit samples, lane 0 in the low bits |

## Verification
The assertions assume that `mode_arb`, `tune_word`, the sweep controls and `arb_last_word` stay steady from arming until the run has stopped. They also assume that the tuning word stays below 2^28, so that the base phase wraps at most once per clock. The stimulus changes these controls only in the idle state. Every run is ended with `stop` before anything is reprogrammed. Tuning values are chosen small and are multiples of one table step, so the expected table addresses and wrap cycles are exact.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    WG_IDLE  = 2'd0,
    WG_ARMED = 2'd1,
    WG_RUN   = 2'd2
  } wg_state_e;
endpackage

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import wg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stop,
  input  logic trig_in,
  output logic start,
  output logic run,
  output logic busy
);
  wg_state_e state;
  logic      trig_d;

  assign start = (state == WG_ARMED) && trig_in && !trig_d && !stop;
  assign run   = (state == WG_RUN);
  assign busy  = (state != WG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WG_IDLE;
      trig_d <= 1'b0;
    end else begin
      trig_d <= trig_in;
      if (stop)                           state <= WG_IDLE;
      else if (state == WG_IDLE && arm)   state <= WG_ARMED;
      else if (start)                     state <= WG_RUN;
    end
  end

  // R4
  run_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(state) == WG_ARMED);

  // R11
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !run && !busy);
endmodule

// File: rtl/wg_dds.sv
module wg_dds #(
  parameter int LANES   = 16,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 11,
  parameter int HOLD_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              run,
  input  logic [PHASE_W-1:0]                tune_word,
  input  logic                              sweep_en,
  input  logic [PHASE_W-1:0]                sweep_step,
  input  logic [PHASE_W-1:0]                sweep_max,
  input  logic [HOLD_W-1:0]                 sweep_hold,
  output logic [LANES-1:0][ADDR_W-1:0]      lane_addr,
  output logic                              wrap
);
  localparam int LOG_LANES = $clog2(LANES);
  localparam int SHIFT     = PHASE_W - ADDR_W;

  logic [PHASE_W-1:0] ph, tw, stride;
  logic [PHASE_W:0]   ph_sum, tw_sum;
  logic [HOLD_W-1:0]  dwell;

  assign stride = tw << LOG_LANES;
  assign ph_sum = {1'b0, ph} + {1'b0, stride};
  assign tw_sum = {1'b0, tw} + {1'b0, sweep_step};
  assign wrap   = ph_sum[PHASE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      tw    <= '0;
      dwell <= '0;
    end else if (start) begin
      ph    <= '0;
      tw    <= tune_word;
      dwell <= '0;
    end else if (run) begin
      ph <= ph_sum[PHASE_W-1:0];
      if (sweep_en) begin
        if (dwell == sweep_hold) begin
          dwell <= '0;
          tw    <= (tw_sum > {1'b0, sweep_max}) ? tune_word : tw_sum[PHASE_W-1:0];
        end else begin
          dwell <= dwell + HOLD_W'(1);
        end
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = ADDR_W'((ph + PHASE_W'(k) * tw) >> SHIFT);
  end

  // R10
  sweep_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && sweep_en |-> (tw <= sweep_max) || (tw == tune_word));
endmodule

// File: rtl/wg_arb.sv
module wg_arb #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 11
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  input  logic                                         run,
  input  logic [ADDR_W-$clog2(LANES)-1:0]              last_word,
  output logic [LANES-1:0][ADDR_W-1:0]                 lane_addr,
  output logic                                         wrap
);
  localparam int LOG_LANES = $clog2(LANES);
  localparam int WORD_W    = ADDR_W - LOG_LANES;

  logic [WORD_W-1:0] idx;

  assign wrap = (idx == last_word);

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (start)  idx <= '0;
    else if (run)    idx <= wrap ? '0 : idx + WORD_W'(1);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = {idx, LOG_LANES'(k)};
  end

  // R8
  arb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> idx <= last_word);
endmodule

// File: rtl/wg_lane_mem.sv
module wg_lane_mem #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 11,
  parameter int SAMPLE_W = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [SAMPLE_W-1:0]                 wr_data,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [SAMPLE_W-1:0]                 rd_data,
  input  logic                                lane_load,
  input  logic [LANES-1:0][ADDR_W-1:0]        lane_addr,
  output logic [LANES-1:0][SAMPLE_W-1:0]      lane_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)         lane_q[k] <= '0;
      else if (lane_load) lane_q[k] <= mem[lane_addr[k]];
      else                lane_q[k] <= '0;
    end
  end
endmodule

// File: rtl/lane_wavegen.sv
module lane_wavegen #(
  parameter int LANES    = 16,
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 11,
  parameter int SAMPLE_W = 14,
  parameter int HOLD_W   = 16,
  localparam int WORD_W  = ADDR_W - $clog2(LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr_en,
  input  logic [ADDR_W-1:0]           host_wr_addr,
  input  logic [SAMPLE_W-1:0]         host_wr_data,
  input  logic [ADDR_W-1:0]           host_rd_addr,
  output logic [SAMPLE_W-1:0]         host_rd_data,
  input  logic                        mode_arb,
  input  logic [PHASE_W-1:0]          tune_word,
  input  logic                        sweep_en,
  input  logic [PHASE_W-1:0]          sweep_step,
  input  logic [PHASE_W-1:0]          sweep_max,
  input  logic [HOLD_W-1:0]           sweep_hold,
  input  logic [WORD_W-1:0]           arb_last_word,
  input  logic                        arm,
  input  logic                        stop,
  input  logic                        trig_in,
  output logic                        trig_out,
  output logic                        smp_valid,
  output logic [LANES*SAMPLE_W-1:0]   smp_lanes
);
  logic start, run, busy, mode_q;
  logic dds_wrap, arb_wrap;
  logic [LANES-1:0][ADDR_W-1:0]   dds_addr, arb_addr, sel_addr;
  logic [LANES-1:0][SAMPLE_W-1:0] lane_q;

  wg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .trig_in(trig_in),
    .start(start), .run(run), .busy(busy)
  );

  wg_dds #(.LANES(LANES), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) u_dds (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .tune_word(tune_word), .sweep_en(sweep_en), .sweep_step(sweep_step),
    .sweep_max(sweep_max), .sweep_hold(sweep_hold),
    .lane_addr(dds_addr), .wrap(dds_wrap)
  );

  wg_arb #(.LANES(LANES), .ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .last_word(arb_last_word), .lane_addr(arb_addr), .wrap(arb_wrap)
  );

  assign sel_addr = mode_q ? arb_addr : dds_addr;

  wg_lane_mem #(.LANES(LANES), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr_en && !busy), .wr_addr(host_wr_addr), .wr_data(host_wr_data),
    .rd_addr(host_rd_addr), .rd_data(host_rd_data),
    .lane_load(run), .lane_addr(sel_addr), .lane_q(lane_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      smp_valid <= 1'b0;
      trig_out  <= 1'b0;
    end else begin
      if (start) mode_q <= mode_arb;
      smp_valid <= run;
      trig_out  <= run && (mode_q ? arb_wrap : dds_wrap);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign smp_lanes[k*SAMPLE_W +: SAMPLE_W] = lane_q[k];
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> smp_lanes == '0);

  // R7
  trig_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> smp_valid);
endmodule

// File: tb/lane_wavegen_bench.sv
module lane_wavegen_bench;
  localparam int LANES = 16;
  localparam int SW    = 14;
  localparam int VW    = LANES * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 1'b0;
  logic [10:0] host_wr_addr = '0;
  logic [SW-1:0] host_wr_data = '0;
  logic [10:0] host_rd_addr = '0;
  logic [SW-1:0] host_rd_data;
  logic mode_arb = 1'b0;
  logic [31:0] tune_word = '0;
  logic sweep_en = 1'b0;
  logic [31:0] sweep_step = '0;
  logic [31:0] sweep_max = '0;
  logic [15:0] sweep_hold = '0;
  logic [6:0] arb_last_word = '0;
  logic arm = 1'b0, stop = 1'b0, trig_in = 1'b0;
  logic trig_out, smp_valid;
  logic [VW-1:0] smp_lanes;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lane_wavegen u_lane_wavegen (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .mode_arb(mode_arb), .tune_word(tune_word), .sweep_en(sweep_en),
    .sweep_step(sweep_step), .sweep_max(sweep_max), .sweep_hold(sweep_hold),
    .arb_last_word(arb_last_word), .arm(arm), .stop(stop), .trig_in(trig_in),
    .trig_out(trig_out), .smp_valid(smp_valid), .smp_lanes(smp_lanes)
  );

  function automatic logic [SW-1:0] pat(int a);
    return SW'(a * 7 + 11);
  endfunction

  function automatic logic [VW-1:0] exp_dds(logic [31:0] ph, logic [31:0] tw);
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) begin
      logic [31:0] p;
      p = ph + 32'(k) * tw;
      v[k*SW +: SW] = pat(int'(p[31:21]));
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] exp_arb(int w);
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*SW +: SW] = pat(w * 16 + k);
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic start_run();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) begin arm = 1'b0; trig_in = 1'b1; end
    @(negedge clk);
    @(negedge clk) trig_in = 1'b0;
  endtask

  task automatic stop_run();
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "valid after reset", VW'(smp_valid), '0);
    check("R1", "trig_out after reset", VW'(trig_out), '0);
    check("R1", "lanes after reset", smp_lanes, '0);
  endtask

  task automatic t_host();
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk) begin
        host_wr_en = 1'b1; host_wr_addr = 11'(a); host_wr_data = pat(a);
      end
    end
    @(negedge clk) host_wr_en = 1'b0;
    foreach (host_rd_addr[i]) ;
    for (int j = 0; j < 3; j++) begin
      int a;
      a = (j == 0) ? 0 : (j == 1) ? 1000 : 2047;
      host_rd_addr = 11'(a);
      @(negedge clk);
      check("R2", "readback", VW'(host_rd_data), VW'(pat(a)));
    end
  endtask

  task automatic t_write_block();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) begin
      arm = 1'b0; host_wr_en = 1'b1; host_wr_addr = 11'd5; host_wr_data = 14'h1234;
    end
    @(negedge clk) begin host_wr_en = 1'b0; host_rd_addr = 11'd5; end
    @(negedge clk);
    check("R3", "entry after armed write", VW'(host_rd_data), VW'(pat(5)));
    stop_run();
  endtask

  task automatic t_dds();
    logic [31:0] ph;
    logic [32:0] s;
    mode_arb = 1'b0; sweep_en = 1'b0; tune_word = 32'h0400_0000;
    @(negedge clk) begin trig_in = 1'b1; arm = 1'b1; end
    @(negedge clk) arm = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", "held-high trigger must not start", VW'(smp_valid), '0);
    trig_in = 1'b0;
    @(negedge clk) trig_in = 1'b1;
    @(negedge clk);
    @(negedge clk) trig_in = 1'b0;
    check("R5", "first word valid", VW'(smp_valid), VW'(1));
    ph = '0;
    for (int n = 0; n < 8; n++) begin
      s = {1'b0, ph} + {1'b0, tune_word << 4};
      check("R6", $sformatf("dds word %0d", n), smp_lanes, exp_dds(ph, tune_word));
      check("R7", $sformatf("dds wrap word %0d", n), VW'(trig_out), VW'(s[32]));
      ph = s[31:0];
      @(negedge clk);
    end
    stop_run();
    check("R11", "valid after stop", VW'(smp_valid), '0);
    check("R11", "lanes after stop", smp_lanes, '0);
  endtask

  task automatic t_cancel();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) begin arm = 1'b0; stop = 1'b1; end
    @(negedge clk) begin stop = 1'b0; trig_in = 1'b1; end
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    check("R11", "cancelled arm ignores trigger", VW'(smp_valid), '0);
  endtask

  task automatic t_arb(input int last, input int words);
    mode_arb = 1'b1; arb_last_word = 7'(last);
    start_run();
    for (int n = 0; n < words; n++) begin
      int w;
      w = n % (last + 1);
      check("R8", $sformatf("arb word %0d", n), smp_lanes, exp_arb(w));
      check("R9", $sformatf("arb marker word %0d", n), VW'(trig_out), VW'(w == last));
      @(negedge clk);
    end
    stop_run();
    mode_arb = 1'b0;
  endtask

  task automatic t_sweep();
    logic [31:0] ph, tw;
    logic [32:0] nx;
    int cnt;
    mode_arb = 1'b0; sweep_en = 1'b1;
    tune_word = 32'h0020_0000; sweep_step = 32'h0020_0000;
    sweep_max = 32'h0060_0000; sweep_hold = 16'd1;
    start_run();
    ph = '0; tw = tune_word; cnt = 0;
    for (int n = 0; n < 12; n++) begin
      check("R10", $sformatf("sweep word %0d", n), smp_lanes, exp_dds(ph, tw));
      ph = ph + (tw << 4);
      if (cnt == int'(sweep_hold)) begin
        cnt = 0;
        nx = {1'b0, tw} + {1'b0, sweep_step};
        tw = (nx > {1'b0, sweep_max}) ? tune_word : nx[31:0];
      end else cnt++;
      @(negedge clk);
    end
    stop_run();
    sweep_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host();
    t_write_block();
    t_dds();
    t_cancel();
    t_arb(2, 9);
    t_arb(127, 130);
    t_sweep();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule